// File: doc/BRIEF.md
# Vector-Register Load Address Generator

This block takes one 32-bit load instruction that moves a single scalar element into a vector/floating-point register. It works out everything the memory pipeline needs before the access starts: the byte address, the element size in bytes, the destination register index and whether the base register is updated. The caller supplies the instruction word, the value of the base register named by the instruction, the current stack-pointer value and a valid strobe. All results appear registered one clock later, together with a valid pulse.

Three addressing forms are recognised. The pre-index form adds a signed 9-bit byte offset before the access and writes the new address back. The post-index form accesses at the unmodified base and writes back base plus offset. The scaled unsigned form adds a 12-bit immediate multiplied by the element size and never writes back. A base index of 31 selects the stack pointer, raises an alignment-check request and steers any writeback to the stack pointer. A word that fits one of the forms but has an illegal size/opcode pairing is flagged undefined. A word that fits none of the forms is flagged not-decoded. Neither flagged case produces an access or a writeback.

The control is a two-state machine. `S_IDLE` means no result is presented. `S_ISSUE` means a result is presented this cycle, with `out_valid` high. The transition `T_ACCEPT` (any state to `S_ISSUE`) fires on a clock edge with `in_valid` high. The transition `T_DRAIN` (any state to `S_IDLE`) fires on an edge with `in_valid` low. The transition `T_RESET` (to `S_IDLE`) fires on a synchronous reset.

Top module: `vec_load_agen`

## Requirements
- R1: `out_valid` is high in exactly the cycle after a clock edge that sampled `in_valid` high, and is low otherwise. A synchronous reset forces `out_valid` and every flag output low on the next edge.
- R2: A word is recognised only in these cases:
  - The indexed forms need bits 29:24 = 111100, bit 22 = 1, bit 21 = 0 and bits 11:10 = 01 (post-index) or 11 (pre-index).
  - The unsigned form needs bits 29:24 = 111101 and bit 22 = 1.
  - Any other word raises `nodec_flag`, with `acc_valid`, `wb_valid`, `undef_flag` and `sp_align_chk` low.
- R3: A recognised word with bit 23 = 1 and bits 31:30 not equal to 00 raises `undef_flag`, with `acc_valid`, `wb_valid` and `sp_align_chk` low.
- R4: The scale is 4 when bit 23 = 1, and bits 31:30 otherwise. `acc_bytes` equals 1 shifted left by the scale, giving 1, 2, 4, 8 or 16.
- R5: Pre-index: `acc_addr` = base + sign-extended bits 20:12, with no scaling. `wb_valid` = 1 and `wb_value` = `acc_addr`.
- R6: Post-index: `acc_addr` = base. `wb_valid` = 1 and `wb_value` = base + sign-extended bits 20:12.
- R7: Unsigned form: `acc_addr` = base + (zero-extended bits 21:10 shifted left by the scale), and `wb_valid` = 0.
- R8: When bits 9:5 equal 31, the base is `sp_val`, `sp_align_chk` is 1 on an access, and `wb_to_sp` is 1 on a writeback. Otherwise the base is `base_val`, and `sp_align_chk` and `wb_to_sp` are 0.
- R9: `dest_idx` equals bits 4:0 and `wb_idx` equals bits 9:5 of the accepted word. Address arithmetic wraps modulo 2^64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Instruction strobe |
| instr | input | 32 | Instruction word |
| base_val | input | 64 | Value of the general base register named by bits 9:5 |
| sp_val | input | 64 | Current stack-pointer value |
| out_valid | output | 1 | Result presented this cycle |
| acc_valid | output | 1 | Memory access requested |
| acc_addr | output | 64 | Access byte address |
| acc_bytes | output | 5 | Access size in bytes |
| dest_idx | output | 5 | Destination vector register index |
| undef_flag | output | 1 | Recognised but undefined encoding |
| nodec_flag | output | 1 | Word matches no supported form |
| sp_align_chk | output | 1 | Stack-pointer alignment check requested |
| wb_valid | output | 1 | Base writeback requested |
| wb_to_sp | output | 1 | Writeback targets the stack pointer |
| wb_idx | output | 5 | Writeback register index |
| wb_value | output | 64 | Writeback value |

## Verification
The access request and the base writeback fall in the same result cycle for both indexed forms. The hardest coincidence is a stack-pointer base, where the alignment request, the stack-pointer writeback and the access all land together. Vectors with base index 31 in pre-index mode (most negative offset, 16-byte element) and post-index mode (largest positive offset, 1-byte element) provoke this case. Each is judged on the shared address for pre-index, and on the unmodified address plus a distinct writeback value for post-index. Undefined stack-pointer words confirm that the alignment request stays low when no access is issued.

// File: rtl/vec_load_agen_pkg.sv
package vec_load_agen_pkg;

    localparam int INSTR_W   = 32;
    localparam int REG_W     = 5;
    localparam int IMM9_W    = 9;
    localparam int IMM12_W   = 12;
    localparam int SCALE_W   = 3;
    localparam int MAX_SCALE = 4;
    localparam int BYTES_W   = MAX_SCALE + 1;
    localparam logic [REG_W-1:0] SP_IDX = '1;

    typedef enum logic [1:0] {
        FORM_NONE,
        FORM_PRE,
        FORM_POST,
        FORM_UOFS
    } form_e;

    typedef struct packed {
        form_e                form;
        logic                 undef;
        logic [SCALE_W-1:0]   scale;
        logic [REG_W-1:0]     rn;
        logic [REG_W-1:0]     rt;
        logic [IMM9_W-1:0]    imm9;
        logic [IMM12_W-1:0]   imm12;
    } dec_t;

endpackage

// File: rtl/vld_decode.sv
module vld_decode
    import vec_load_agen_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    output dec_t               dec
);
    logic [1:0] size_f;
    logic       opc_hi;
    logic       opc_lo;
    logic       idx_grp;
    logic       uofs_grp;
    logic [1:0] mode_f;

    always_comb begin
        size_f   = instr[31:30];
        opc_hi   = instr[23];
        opc_lo   = instr[22];
        mode_f   = instr[11:10];
        idx_grp  = (instr[29:24] == 6'b111100) && opc_lo && !instr[21];
        uofs_grp = (instr[29:24] == 6'b111101) && opc_lo;

        dec.form = FORM_NONE;
        if (uofs_grp)
            dec.form = FORM_UOFS;
        else if (idx_grp && mode_f == 2'b11)
            dec.form = FORM_PRE;
        else if (idx_grp && mode_f == 2'b01)
            dec.form = FORM_POST;

        dec.undef = (dec.form != FORM_NONE) && opc_hi && (size_f != 2'b00);
        dec.scale = opc_hi ? SCALE_W'(MAX_SCALE) : {1'b0, size_f};
        dec.rn    = instr[9:5];
        dec.rt    = instr[4:0];
        dec.imm9  = instr[20:12];
        dec.imm12 = instr[21:10];
    end
endmodule

// File: rtl/vld_agen.sv
module vld_agen
    import vec_load_agen_pkg::*;
#(
    parameter int ADDR_W = 64
) (
    input  form_e               form,
    input  logic [SCALE_W-1:0]  scale,
    input  logic [REG_W-1:0]    rn,
    input  logic [IMM9_W-1:0]   imm9,
    input  logic [IMM12_W-1:0]  imm12,
    input  logic [ADDR_W-1:0]   base_val,
    input  logic [ADDR_W-1:0]   sp_val,
    output logic [ADDR_W-1:0]   addr,
    output logic [ADDR_W-1:0]   wb_val,
    output logic [BYTES_W-1:0]  nbytes,
    output logic                use_sp
);
    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] ofs_signed;
    logic [ADDR_W-1:0] ofs_scaled;
    logic [ADDR_W-1:0] sum_signed;

    always_comb begin
        use_sp     = (rn == SP_IDX);
        base       = use_sp ? sp_val : base_val;
        ofs_signed = {{(ADDR_W-IMM9_W){imm9[IMM9_W-1]}}, imm9};
        ofs_scaled = ADDR_W'(imm12) << scale;
        sum_signed = base + ofs_signed;
        nbytes     = BYTES_W'(1) << scale;

        unique case (form)
            FORM_PRE:  begin addr = sum_signed;        wb_val = sum_signed; end
            FORM_POST: begin addr = base;              wb_val = sum_signed; end
            FORM_UOFS: begin addr = base + ofs_scaled; wb_val = base;       end
            default:   begin addr = base;              wb_val = base;       end
        endcase
    end
endmodule

// File: rtl/vec_load_agen.sv
module vec_load_agen
    import vec_load_agen_pkg::*;
#(
    parameter int ADDR_W = 64
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic [31:0]          instr,
    input  logic [ADDR_W-1:0]    base_val,
    input  logic [ADDR_W-1:0]    sp_val,
    output logic                 out_valid,
    output logic                 acc_valid,
    output logic [ADDR_W-1:0]    acc_addr,
    output logic [4:0]           acc_bytes,
    output logic [4:0]           dest_idx,
    output logic                 undef_flag,
    output logic                 nodec_flag,
    output logic                 sp_align_chk,
    output logic                 wb_valid,
    output logic                 wb_to_sp,
    output logic [4:0]           wb_idx,
    output logic [ADDR_W-1:0]    wb_value
);
    typedef enum logic {S_IDLE, S_ISSUE} state_e;

    state_e state, state_nxt;

    dec_t               dec;
    logic [ADDR_W-1:0]  addr_c;
    logic [ADDR_W-1:0]  wbv_c;
    logic [BYTES_W-1:0] nbytes_c;
    logic               use_sp_c;
    logic               legal_c;
    logic               wb_c;

    vld_decode u_dec (
        .instr (instr),
        .dec   (dec)
    );

    vld_agen #(.ADDR_W(ADDR_W)) u_agen (
        .form     (dec.form),
        .scale    (dec.scale),
        .rn       (dec.rn),
        .imm9     (dec.imm9),
        .imm12    (dec.imm12),
        .base_val (base_val),
        .sp_val   (sp_val),
        .addr     (addr_c),
        .wb_val   (wbv_c),
        .nbytes   (nbytes_c),
        .use_sp   (use_sp_c)
    );

    always_comb begin
        legal_c = (dec.form != FORM_NONE) && !dec.undef;
        wb_c    = legal_c && (dec.form == FORM_PRE || dec.form == FORM_POST);
    end

    // Next-state logic: T_ACCEPT / T_DRAIN
    always_comb begin
        unique case (state)
            S_IDLE:  state_nxt = in_valid ? S_ISSUE : S_IDLE;
            S_ISSUE: state_nxt = in_valid ? S_ISSUE : S_IDLE;
            default: state_nxt = S_IDLE;
        endcase
    end

    // State register, T_RESET
    always_ff @(posedge clk) begin
        if (rst) state <= S_IDLE;
        else     state <= state_nxt;
    end

    assign out_valid = (state == S_ISSUE);

    // Output registers
    always_ff @(posedge clk) begin
        if (rst) begin
            acc_valid    <= 1'b0;
            undef_flag   <= 1'b0;
            nodec_flag   <= 1'b0;
            sp_align_chk <= 1'b0;
            wb_valid     <= 1'b0;
            wb_to_sp     <= 1'b0;
            acc_addr     <= '0;
            acc_bytes    <= '0;
            dest_idx     <= '0;
            wb_idx       <= '0;
            wb_value     <= '0;
        end else begin
            acc_valid    <= in_valid && legal_c;
            undef_flag   <= in_valid && dec.undef;
            nodec_flag   <= in_valid && (dec.form == FORM_NONE);
            sp_align_chk <= in_valid && legal_c && use_sp_c;
            wb_valid     <= in_valid && wb_c;
            wb_to_sp     <= in_valid && wb_c && use_sp_c;
            if (in_valid) begin
                acc_addr  <= addr_c;
                acc_bytes <= nbytes_c;
                dest_idx  <= dec.rt;
                wb_idx    <= dec.rn;
                wb_value  <= wbv_c;
            end
        end
    end
endmodule

// File: rtl/vec_load_agen_chk.sv
module vec_load_agen_chk #(
    parameter int ADDR_W = 64
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [31:0]       instr,
    input logic              out_valid,
    input logic              acc_valid,
    input logic [ADDR_W-1:0] acc_addr,
    input logic [4:0]        acc_bytes,
    input logic              undef_flag,
    input logic              nodec_flag,
    input logic              sp_align_chk,
    input logic              wb_valid,
    input logic              wb_to_sp,
    input logic [ADDR_W-1:0] wb_value
);
    // R1
    valid_follows_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    // R1
    valid_drops_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    // R2
    nodec_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        nodec_flag |-> !acc_valid && !wb_valid && !undef_flag && !sp_align_chk);
    // R3
    undef_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        undef_flag |-> !acc_valid && !wb_valid && !sp_align_chk);
    // R4
    size_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        acc_valid |-> $countones(acc_bytes) == 1);
    // R5
    pre_shared_chk: assert property (@(posedge clk) disable iff (rst)
        wb_valid && !$past(instr[24]) && $past(instr[11:10]) == 2'b11 |-> wb_value == acc_addr);
    // R6
    post_offset_chk: assert property (@(posedge clk) disable iff (rst)
        wb_valid && $past(instr[11:10]) == 2'b01 |->
        wb_value == acc_addr + {{(ADDR_W-9){$past(instr[20])}}, $past(instr[20:12])});
    // R7
    uofs_no_wb_chk: assert property (@(posedge clk) disable iff (rst)
        acc_valid && $past(instr[24]) |-> !wb_valid);
    // R8
    align_needs_acc_chk: assert property (@(posedge clk) disable iff (rst)
        (sp_align_chk || wb_valid) |-> acc_valid && out_valid);
    // R8
    sp_wb_pair_chk: assert property (@(posedge clk) disable iff (rst)
        wb_to_sp |-> wb_valid && sp_align_chk);
endmodule

bind vec_load_agen vec_load_agen_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .in_valid     (in_valid),
    .instr        (instr),
    .out_valid    (out_valid),
    .acc_valid    (acc_valid),
    .acc_addr     (acc_addr),
    .acc_bytes    (acc_bytes),
    .undef_flag   (undef_flag),
    .nodec_flag   (nodec_flag),
    .sp_align_chk (sp_align_chk),
    .wb_valid     (wb_valid),
    .wb_to_sp     (wb_to_sp),
    .wb_value     (wb_value)
);

// File: tb/vec_load_agen_test.sv
module vec_load_agen_test;

    function automatic logic [31:0] enc_idx(input logic [1:0] sz, input logic oh,
                                            input logic [8:0] im, input logic [1:0] md,
                                            input logic [4:0] rn, input logic [4:0] rt);
        return {sz, 3'b111, 1'b1, 2'b00, oh, 1'b1, 1'b0, im, md, rn, rt};
    endfunction

    function automatic logic [31:0] enc_uns(input logic [1:0] sz, input logic oh,
                                            input logic [11:0] im,
                                            input logic [4:0] rn, input logic [4:0] rt);
        return {sz, 3'b111, 1'b1, 2'b01, oh, 1'b1, im, rn, rt};
    endfunction

    typedef struct packed {
        logic [31:0] ins;
        logic [63:0] base;
        logic [63:0] sp;
        logic        e_acc;
        logic        e_undef;
        logic        e_nodec;
        logic [4:0]  e_bytes;
        logic [63:0] e_addr;
        logic        e_wb;
        logic [63:0] e_wbv;
        logic        e_align;
    } vec_t;

    localparam int NV = 14;
    localparam logic [63:0] B0 = 64'h1000;
    localparam logic [63:0] S0 = 64'h8000;

    localparam vec_t VECS [NV] = '{
        // R5 pre-index, 4 bytes, +16
        '{enc_idx(2'd2, 1'b0, 9'h010, 2'b11, 5'd3, 5'd7), B0, S0, 1'b1, 1'b0, 1'b0, 5'd4, 64'h1010, 1'b1, 64'h1010, 1'b0},
        // R6 post-index, 8 bytes, -8
        '{enc_idx(2'd3, 1'b0, 9'h1F8, 2'b01, 5'd4, 5'd1), B0, S0, 1'b1, 1'b0, 1'b0, 5'd8, 64'h1000, 1'b1, 64'h0FF8, 1'b0},
        // R8 pre-index on SP, 16 bytes, -256
        '{enc_idx(2'd0, 1'b1, 9'h100, 2'b11, 5'd31, 5'd9), B0, S0, 1'b1, 1'b0, 1'b0, 5'd16, 64'h7F00, 1'b1, 64'h7F00, 1'b1},
        // R8 post-index on SP, 1 byte, +255
        '{enc_idx(2'd0, 1'b0, 9'h0FF, 2'b01, 5'd31, 5'd2), B0, S0, 1'b1, 1'b0, 1'b0, 5'd1, 64'h8000, 1'b1, 64'h80FF, 1'b1},
        // R7 unsigned, 2 bytes, max imm
        '{enc_uns(2'd1, 1'b0, 12'hFFF, 5'd2, 5'd30), B0, S0, 1'b1, 1'b0, 1'b0, 5'd2, 64'h2FFE, 1'b0, 64'h0, 1'b0},
        // R7 unsigned, 16 bytes, max imm (65520)
        '{enc_uns(2'd0, 1'b1, 12'hFFF, 5'd5, 5'd0), B0, S0, 1'b1, 1'b0, 1'b0, 5'd16, 64'h10FF0, 1'b0, 64'h0, 1'b0},
        // R7 R8 unsigned on SP, 8 bytes
        '{enc_uns(2'd3, 1'b0, 12'h001, 5'd31, 5'd4), B0, S0, 1'b1, 1'b0, 1'b0, 5'd8, 64'h8008, 1'b0, 64'h0, 1'b1},
        // R3 undefined indexed
        '{enc_idx(2'd1, 1'b1, 9'h004, 2'b11, 5'd6, 5'd6), B0, S0, 1'b0, 1'b1, 1'b0, 5'd0, 64'h0, 1'b0, 64'h0, 1'b0},
        // R3 undefined unsigned on SP
        '{enc_uns(2'd3, 1'b1, 12'h010, 5'd31, 5'd8), B0, S0, 1'b0, 1'b1, 1'b0, 5'd0, 64'h0, 1'b0, 64'h0, 1'b0},
        // R2 mode 00
        '{enc_idx(2'd2, 1'b0, 9'h004, 2'b00, 5'd1, 5'd1), B0, S0, 1'b0, 1'b0, 1'b1, 5'd0, 64'h0, 1'b0, 64'h0, 1'b0},
        // R2 bit 22 clear
        '{enc_idx(2'd2, 1'b0, 9'h004, 2'b11, 5'd1, 5'd1) & ~32'h0040_0000, B0, S0, 1'b0, 1'b0, 1'b1, 5'd0, 64'h0, 1'b0, 64'h0, 1'b0},
        // R2 bit 21 set
        '{enc_idx(2'd2, 1'b0, 9'h004, 2'b01, 5'd1, 5'd1) | 32'h0020_0000, B0, S0, 1'b0, 1'b0, 1'b1, 5'd0, 64'h0, 1'b0, 64'h0, 1'b0},
        // R2 zero word
        '{32'h0000_0000, B0, S0, 1'b0, 1'b0, 1'b1, 5'd0, 64'h0, 1'b0, 64'h0, 1'b0},
        // R9 wrap below zero, pre-index -1
        '{enc_idx(2'd2, 1'b0, 9'h1FF, 2'b11, 5'd10, 5'd11), 64'h0, S0, 1'b1, 1'b0, 1'b0, 5'd4, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [31:0] instr;
    logic [63:0] base_val, sp_val;
    logic        out_valid, acc_valid, undef_flag, nodec_flag, sp_align_chk;
    logic        wb_valid, wb_to_sp;
    logic [63:0] acc_addr, wb_value;
    logic [4:0]  acc_bytes, dest_idx, wb_idx;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    vec_load_agen uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr),
        .base_val(base_val), .sp_val(sp_val), .out_valid(out_valid),
        .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_bytes(acc_bytes),
        .dest_idx(dest_idx), .undef_flag(undef_flag), .nodec_flag(nodec_flag),
        .sp_align_chk(sp_align_chk), .wb_valid(wb_valid), .wb_to_sp(wb_to_sp),
        .wb_idx(wb_idx), .wb_value(wb_value)
    );

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_bad++;
            $display("FAIL R1 watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; in_valid = 1'b0; instr = '0; base_val = '0; sp_val = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", "out_valid in reset", 64'(out_valid), 64'd0);
        chk("R1", "acc_valid in reset", 64'(acc_valid), 64'd0);
        rst = 1'b0;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            instr = VECS[i].ins; base_val = VECS[i].base; sp_val = VECS[i].sp;
            in_valid = 1'b1;
            @(negedge clk);
            chk("R1", "out_valid", 64'(out_valid), 64'd1);
            chk("R2", "nodec_flag", 64'(nodec_flag), 64'(VECS[i].e_nodec));
            chk("R3", "undef_flag", 64'(undef_flag), 64'(VECS[i].e_undef));
            chk("R2", "acc_valid", 64'(acc_valid), 64'(VECS[i].e_acc));
            chk("R6", "wb_valid", 64'(wb_valid), 64'(VECS[i].e_wb));
            chk("R8", "sp_align_chk", 64'(sp_align_chk), 64'(VECS[i].e_align));
            chk("R8", "wb_to_sp", 64'(wb_to_sp), 64'(VECS[i].e_wb && VECS[i].e_align));
            if (VECS[i].e_acc) begin
                chk("R5", "acc_addr", acc_addr, VECS[i].e_addr);
                chk("R4", "acc_bytes", 64'(acc_bytes), 64'(VECS[i].e_bytes));
                chk("R9", "dest_idx", 64'(dest_idx), 64'(VECS[i].ins[4:0]));
            end
            if (VECS[i].e_wb) begin
                chk("R6", "wb_value", wb_value, VECS[i].e_wbv);
                chk("R9", "wb_idx", 64'(wb_idx), 64'(VECS[i].ins[9:5]));
            end
        end

        // R1 idle cycle with a legal word held: nothing presented
        in_valid = 1'b0;
        instr = enc_idx(2'd2, 1'b0, 9'h010, 2'b11, 5'd3, 5'd7);
        @(negedge clk);
        chk("R1", "out_valid idle", 64'(out_valid), 64'd0);
        chk("R1", "acc_valid idle", 64'(acc_valid), 64'd0);
        chk("R1", "wb_valid idle", 64'(wb_valid), 64'd0);

        // R4 scale sweep through the unsigned form, imm 1
        for (int s = 0; s < 5; s++) begin
            logic [1:0] sz;
            sz = (s == 4) ? 2'd0 : 2'(s);
            instr = enc_uns(sz, s == 4, 12'h001, 5'd0, 5'd0);
            base_val = 64'h4000;
            in_valid = 1'b1;
            @(negedge clk);
            chk("R4", "acc_bytes sweep", 64'(acc_bytes), 64'd1 << s);
            chk("R7", "acc_addr sweep", acc_addr, 64'h4000 + (64'd1 << s));
        end

        // R8 base 30 must not pick the stack pointer
        instr = enc_idx(2'd2, 1'b0, 9'h000, 2'b01, 5'd30, 5'd0);
        base_val = 64'hAAAA; sp_val = 64'h5555;
        @(negedge clk);
        chk("R8", "base 30 addr", acc_addr, 64'hAAAA);
        chk("R8", "base 30 align", 64'(sp_align_chk), 64'd0);

        // R1 reset while valid held
        rst = 1'b1;
        @(negedge clk);
        chk("R1", "out_valid after reset", 64'(out_valid), 64'd0);
        chk("R1", "wb_valid after reset", 64'(wb_valid), 64'd0);
        rst = 1'b0; in_valid = 1'b0;
        @(negedge clk);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule